// File: doc/BRIEF.md
# Word FIFO Pair with Interrupt Status

This block sits between a register port and a serial flash engine. It holds two word queues: a transmit queue that the host fills and the engine drains, and a receive queue that the engine fills and the host drains. Both queues hold 32-bit words. One packed status word reports the full and empty flags of both queues, the free slots left in the transmit queue and the words waiting in the receive queue. Software can therefore move a burst of words with a single status read.

The block also holds the interrupt logic of the controller. Eight event sources are latched into a sticky raw status vector. A mask register removes sources from the interrupt, where a 1 disables a source. The raw bits that survive the mask form the masked status vector, and their OR drives the interrupt line. Writing 1 to a bit of the clear port drops that raw bit. Two of the sources are level comparisons against programmable thresholds. Two are access errors: a host read from an empty receive queue, and a host write into a full transmit queue. The last four are pulses from the serial engine. A recovery input empties both queues and leaves the interrupt state alone.

Top module: `xfer_fifo_irq`

## Requirements
- R1: While reset is held, the status word reads DEPTH free TX slots with the TX-empty and RX-empty flags set, the RX level is 0, raw status is 0, the mask is all ones and irq is low.
- R2: The status word carries TX full in bit 0, TX empty in bit 1, RX empty in bit 2 and RX full in bit 3. It carries the TX free-slot count in bits 12:8 and the RX word count in bits 20:16. All other bits are 0.
- R3: Words written on the host TX port leave in the same order on the engine TX port. Each word appears on the engine data output in the cycle after its pop.
- R4: Words pushed by the engine leave in the same order on the host RX port. Each word appears on the host read data output in the cycle after the read.
- R5: A host read while the RX queue is empty returns zero, leaves the RX level unchanged and sets raw bit 1.
- R6: A host write while the TX queue is full is dropped, leaves the queue contents and level unchanged and sets raw bit 2.
- R7: The TX threshold is written through a 5-bit port and the RX threshold through another 5-bit port. They read back in the configuration word at bits 4:0 and bits 12:8. Raw bit 0 is set while the RX word count is above the RX threshold. Raw bit 3 is set while the TX free-slot count is above the TX threshold. Both thresholds reset to DEPTH.
- R8: Engine event inputs 0 to 3 (transfer finish, bus error, protocol error, DMA done) set raw bits 4 to 7 in the cycle they are high.
- R9: The masked status is the raw status with every bit cleared where the mask holds a 1. irq is the OR of the masked status. Raw bits keep latching while masked.
- R10: A clear write drops each raw bit written as 1 and leaves the others unchanged. A source that is active in the same cycle as a clear wins, and its bit stays set.
- R11: A recovery pulse empties both queues, giving DEPTH free TX slots and 0 RX words. Raw status and the mask are unchanged.
- R12: An engine pop from an empty TX queue and an engine push into a full RX queue change neither queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| recover | input | 1 | Empties both queues |
| tx_wr | input | 1 | Host writes a TX word |
| tx_wdata | input | 32 | Host TX word |
| rx_rd | input | 1 | Host reads an RX word |
| rx_rdata | output | 32 | Host RX word, registered |
| eng_tx_pop | input | 1 | Engine takes a TX word |
| eng_tx_data | output | 32 | TX word for the engine, registered |
| eng_rx_push | input | 1 | Engine stores an RX word |
| eng_rx_data | input | 32 | RX word from the engine |
| eng_events | input | 4 | Finish, bus error, protocol error, DMA done pulses |
| thr_we | input | 1 | Loads both thresholds |
| tx_thr_wdata | input | 5 | New TX threshold |
| rx_thr_wdata | input | 5 | New RX threshold |
| thr_cfg | output | 16 | Threshold readback |
| mask_we | input | 1 | Loads the mask |
| mask_wdata | input | 8 | New mask, 1 disables a source |
| clr_we | input | 1 | Clear strobe |
| clr_wdata | input | 8 | Raw bits to clear |
| fifo_status | output | 32 | Packed flags and levels |
| raw_status | output | 8 | Sticky raw sources |
| masked_status | output | 8 | Raw sources that pass the mask |
| irq_mask | output | 8 | Current mask |
| irq | output | 1 | Interrupt line |

## Verification
The queue assertions assume a push that finds its queue full is dropped and a pop that finds it empty is ignored, so they hold for any host or engine access pattern. The interrupt assertions assume that the event inputs and clear writes are single-cycle strobes sampled at the clock edge. The stimulus drives every strobe for exactly one cycle, away from the active edge. With a depth of four, it sweeps every fill level of both queues and every threshold against every level. It also sweeps all 256 mask values over a fixed raw pattern.

// File: rtl/xfq_pkg.sv
package xfq_pkg;
  localparam int LVLW = 5;   // width of level and threshold fields
  localparam int NSRC = 8;   // interrupt sources
  localparam int SRC_RX_LVL  = 0;
  localparam int SRC_RX_UNDR = 1;
  localparam int SRC_TX_OVR  = 2;
  localparam int SRC_TX_LVL  = 3;
  localparam int SRC_ENG0    = 4;
endpackage

// File: rtl/xfq_word_fifo.sv
module xfq_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pop_data <= '0;
    else if (pop) pop_data <= empty ? '0 : mem[rp];
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R6
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> count == $past(count));
  // R5
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> pop_data == '0);
  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0);
endmodule

// File: rtl/xfq_irq_regs.sv
module xfq_irq_regs #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic         clr_we,
  input  logic [N-1:0] clr_wdata,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic [N-1:0] masked,
  output logic         irq
);
  logic [N-1:0] clr_bits;

  assign clr_bits = clr_we ? clr_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= '0;
      mask <= '1;
    end else begin
      raw <= (raw & ~clr_bits) | set_vec;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign masked = raw & ~mask;
  assign irq    = |masked;

  // R9
  src_latches_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> (($past(set_vec) & ~raw) == '0));
  // R10
  sticky_until_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (raw != '0) |=> (($past(raw & ~clr_bits) & ~raw) == '0));
endmodule

// File: rtl/xfer_fifo_irq.sv
module xfer_fifo_irq
  import xfq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            recover,
  input  logic            tx_wr,
  input  logic [W-1:0]    tx_wdata,
  input  logic            rx_rd,
  output logic [W-1:0]    rx_rdata,
  input  logic            eng_tx_pop,
  output logic [W-1:0]    eng_tx_data,
  input  logic            eng_rx_push,
  input  logic [W-1:0]    eng_rx_data,
  input  logic [3:0]      eng_events,
  input  logic            thr_we,
  input  logic [LVLW-1:0] tx_thr_wdata,
  input  logic [LVLW-1:0] rx_thr_wdata,
  output logic [15:0]     thr_cfg,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_wdata,
  output logic [31:0]     fifo_status,
  output logic [NSRC-1:0] raw_status,
  output logic [NSRC-1:0] masked_status,
  output logic [NSRC-1:0] irq_mask,
  output logic            irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]   tx_cnt, rx_cnt, tx_free;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [LVLW-1:0] tx_thr, rx_thr, tx_lvl, rx_lvl;
  logic [NSRC-1:0] set_vec;

  xfq_word_fifo #(.W(W), .DEPTH(DEPTH)) tx_q_i (
    .clk(clk), .rst(rst), .flush(recover),
    .push(tx_wr), .push_data(tx_wdata),
    .pop(eng_tx_pop), .pop_data(eng_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  xfq_word_fifo #(.W(W), .DEPTH(DEPTH)) rx_q_i (
    .clk(clk), .rst(rst), .flush(recover),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(rx_rd), .pop_data(rx_rdata),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr <= LVLW'(DEPTH);
      rx_thr <= LVLW'(DEPTH);
    end else if (thr_we) begin
      tx_thr <= tx_thr_wdata;
      rx_thr <= rx_thr_wdata;
    end
  end

  assign tx_free = CW'(DEPTH) - tx_cnt;
  assign tx_lvl  = LVLW'(tx_free);
  assign rx_lvl  = LVLW'(rx_cnt);
  assign thr_cfg = {3'b000, rx_thr, 3'b000, tx_thr};

  assign fifo_status = {11'd0, rx_lvl, 3'd0, tx_lvl, 4'd0,
                        rx_full, rx_empty, tx_empty, tx_full};

  always_comb begin
    set_vec              = '0;
    set_vec[SRC_RX_LVL]  = rx_lvl > rx_thr;
    set_vec[SRC_RX_UNDR] = rx_rd && rx_empty;
    set_vec[SRC_TX_OVR]  = tx_wr && tx_full;
    set_vec[SRC_TX_LVL]  = tx_lvl > tx_thr;
    set_vec[SRC_ENG0 +: 4] = eng_events;
  end

  xfq_irq_regs #(.N(NSRC)) irq_i (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .raw(raw_status), .mask(irq_mask),
    .masked(masked_status), .irq(irq));
endmodule

// File: tb/xfer_fifo_irq_tb_top.sv
module xfer_fifo_irq_tb_top;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        recover = 0, tx_wr = 0, rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [31:0] tx_wdata = 0, eng_rx_data = 0;
  logic [31:0] rx_rdata, eng_tx_data, fifo_status;
  logic [3:0]  eng_events = 0;
  logic        thr_we = 0, mask_we = 0, clr_we = 0;
  logic [4:0]  tx_thr_wdata = 0, rx_thr_wdata = 0;
  logic [15:0] thr_cfg;
  logic [7:0]  mask_wdata = 0, clr_wdata = 0;
  logic [7:0]  raw_status, masked_status, irq_mask;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xfer_fifo_irq #(.DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .recover(recover),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_events(eng_events), .thr_we(thr_we),
    .tx_thr_wdata(tx_thr_wdata), .rx_thr_wdata(rx_thr_wdata), .thr_cfg(thr_cfg),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .fifo_status(fifo_status), .raw_status(raw_status),
    .masked_status(masked_status), .irq_mask(irq_mask), .irq(irq));

  function automatic logic [31:0] stat(int txu, int rxl);
    return ((D - txu) << 8) | (rxl << 16) | ((rxl == D) << 3) |
           ((rxl == 0) << 2) | ((txu == 0) << 1) | (txu == D);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic host_wr(logic [31:0] d); tx_wr = 1; tx_wdata = d; tick(); tx_wr = 0; endtask
  task automatic eng_push(logic [31:0] d); eng_rx_push = 1; eng_rx_data = d; tick(); eng_rx_push = 0; endtask
  task automatic host_rd(); rx_rd = 1; tick(); rx_rd = 0; endtask
  task automatic eng_pop(); eng_tx_pop = 1; tick(); eng_tx_pop = 0; endtask
  task automatic set_thr(int t, int r);
    thr_we = 1; tx_thr_wdata = 5'(t); rx_thr_wdata = 5'(r); tick(); thr_we = 0;
  endtask
  task automatic wr_mask(logic [7:0] m); mask_we = 1; mask_wdata = m; tick(); mask_we = 0; endtask
  task automatic wr_clr(logic [7:0] c); clr_we = 1; clr_wdata = c; tick(); clr_we = 0; endtask
  task automatic do_recover(); recover = 1; tick(); recover = 0; endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    // R1 reset state, sampled while reset is held
    chk("R1 status", fifo_status, stat(0, 0));
    chk("R1 raw", {24'd0, raw_status}, 32'h0);
    chk("R1 mask", {24'd0, irq_mask}, 32'hFF);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R7 thr reset", {16'd0, thr_cfg}, (D << 8) | D);
    rst = 0; tick();

    // R2 R3 R6 R12: TX fill sweep, overflow, ordered drain, two patterns
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l <= D; l++) begin
        chk("R2 tx level", fifo_status, stat(l, 0));
        if (l < D) host_wr((p == 0) ? 32'hA5000000 + l : ~(32'h00010000 * (l + 1)));
      end
      wr_clr(8'hFF);
      host_wr(32'hDEADBEEF);
      chk("R6 ovf bit", {31'd0, raw_status[2]}, 32'h1);
      chk("R6 ovf level", fifo_status, stat(D, 0));
      for (int l = 0; l < D; l++) begin
        eng_pop();
        chk("R3 tx order", eng_tx_data,
            (p == 0) ? 32'hA5000000 + l : ~(32'h00010000 * (l + 1)));
      end
      eng_pop();
      chk("R12 tx empty pop", fifo_status, stat(0, 0));
    end

    // R2 R4 R5 R12: RX fill sweep, overfill ignored, ordered drain, underflow
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l <= D; l++) begin
        chk("R2 rx level", fifo_status, stat(0, l));
        if (l < D) eng_push((p == 0) ? 32'h3C000000 + l * 7 : 32'hFFFF0000 >> l);
      end
      eng_push(32'h12345678);
      chk("R12 rx full push", fifo_status, stat(0, D));
      for (int l = 0; l < D; l++) begin
        host_rd();
        chk("R4 rx order", rx_rdata, (p == 0) ? 32'h3C000000 + l * 7 : 32'hFFFF0000 >> l);
      end
      wr_clr(8'hFF);
      chk("R5 no undr yet", {31'd0, raw_status[1]}, 32'h0);
      host_rd();
      chk("R5 undr data", rx_rdata, 32'h0);
      chk("R5 undr bit", {31'd0, raw_status[1]}, 32'h1);
      chk("R5 undr level", fifo_status, stat(0, 0));
    end

    // R7 threshold sweep against every level
    for (int t = 0; t <= D; t++) begin
      for (int l = 0; l <= D; l++) begin
        do_recover();
        for (int k = 0; k < l; k++) eng_push(32'(k));
        set_thr(D, t);
        chk("R7 thr readback", {16'd0, thr_cfg}, (t << 8) | D);
        wr_clr(8'hFF);
        chk("R7 rx thr", {24'd0, raw_status}, (l > t) ? 32'h1 : 32'h0);
        do_recover();
        for (int k = 0; k < l; k++) host_wr(32'(k));
        set_thr(t, D);
        wr_clr(8'hFF);
        chk("R7 tx thr", {24'd0, raw_status}, ((D - l) > t) ? 32'h8 : 32'h0);
      end
    end
    set_thr(D, D);

    // R11 recovery keeps raw and mask
    host_wr(32'h1); eng_push(32'h2); eng_push(32'h3);
    wr_clr(8'hFF); wr_mask(8'h5A);
    eng_events = 4'b0010; tick(); eng_events = 0;
    do_recover();
    chk("R11 levels idle", fifo_status, stat(0, 0));
    chk("R11 raw kept", {24'd0, raw_status}, 32'h20);
    chk("R11 mask kept", {24'd0, irq_mask}, 32'h5A);
    wr_mask(8'hFF);

    // R8 R10 each engine event and its clear
    for (int k = 0; k < 4; k++) begin
      wr_clr(8'hFF);
      eng_events = 4'(1 << k); tick(); eng_events = 0;
      chk("R8 event latch", {24'd0, raw_status}, 32'(1 << (4 + k)));
      wr_clr(8'(1 << (4 + k)) ^ 8'h0F);
      chk("R10 partial clear", {24'd0, raw_status}, 32'h0);
    end
    eng_events = 4'hF; tick(); eng_events = 0;
    wr_clr(8'h00);
    chk("R10 zero clear", {24'd0, raw_status}, 32'hF0);
    wr_clr(8'h10);
    chk("R10 one bit", {24'd0, raw_status}, 32'hE0);
    clr_we = 1; clr_wdata = 8'h20; eng_events = 4'b0010; tick();
    clr_we = 0; eng_events = 0;
    chk("R10 set wins", {24'd0, raw_status}, 32'hE0);

    // R9 mask sweep over raw 0xF0
    eng_events = 4'hF; tick(); eng_events = 0;
    chk("R9 masked latch", {24'd0, raw_status}, 32'hF0);
    chk("R9 all masked irq", {31'd0, irq}, 32'h0);
    for (int m = 0; m < 256; m++) begin
      wr_mask(8'(m));
      chk("R9 masked", {24'd0, masked_status}, 32'hF0 & ~32'(m) & 32'hFF);
      chk("R9 irq", {31'd0, irq}, ((8'hF0 & ~8'(m)) != 0) ? 32'h1 : 32'h0);
    end
    wr_mask(8'h00);
    wr_clr(8'hFF);
    chk("R9 irq cleared", {31'd0, irq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule